// File: doc/BRIEF.md
# Dual Alarm Comparator with Interrupt Routing

This block watches a running calendar time and raises alarm interrupts. It holds two alarm slots. Each slot has four BCD bytes: seconds, minutes, hours and weekday. On every one-second tick, each slot's four bytes are compared with the current time. Any byte whose top bit is set is treated as "match anything". When a slot matches, it sets a sticky flag. Each flag can be gated onto active-low interrupt lines by enable bits in a small control register. A routing bit in that register decides whether the second alarm gets its own line or shares the first one.

The seconds counter and the serial register interface are outside this block. They arrive as a tick pulse, four time bytes, and a byte-wide register port with separate write and read strobes. Each flag clears as a side effect of reading any register of its own alarm. A write to the status register can also clear flags. A new match that lands in the same cycle as a clear always wins, so no alarm event is lost.

Top module: `alarm_match_irq`

## Requirements
- R1: After reset, every alarm byte, the control register, both flags and the read data are zero, and both `int0_n` and `int1_n` are high.
- R2: The alarm bytes are read/write registers. Alarm 0 uses addresses 0x07 (sec), 0x08 (min), 0x09 (hour) and 0x0A (weekday). Alarm 1 uses 0x0B to 0x0E in the same field order. Read data appears on `reg_rdata` in the cycle after the read strobe and holds until the next read. An unmapped address reads as 0x00.
- R3: On a cycle with `sec_tick` high, an alarm matches when every one of its four bytes either has bit 7 set or equals the corresponding time byte. A match sets that alarm's flag. Without a tick, no flag is set.
- R4: A set flag stays set after the time moves past the match, until it is cleared.
- R5: A read of any of the four registers of an alarm clears that alarm's flag only.
- R6: A write to the status register (0x10) clears each flag whose data bit is 0 and leaves alone each flag whose data bit is 1. Data bit 0 belongs to alarm 0 and data bit 1 to alarm 1.
- R7: A match in the same cycle as a clearing read or status write leaves the flag set.
- R8: `int0_n` is low exactly when either of these holds:
  - flag 0 and control bit 0 are both set;
  - control bit 2 is clear, and flag 1 and control bit 1 are both set.
- R9: `int1_n` is low exactly when control bit 2 is set and flag 1 and control bit 1 are both set.
- R10: The control register is at 0x0F and stores bits 2:0, with the upper bits reading as 0. The status register at 0x10 reads flag 0 in bit 0 and flag 1 in bit 1. Reading status does not clear the flags.
- R11: The hours byte is compared as raw bits, including the 12-hour bit (bit 6) and the PM bit (bit 5). So 0x52 does not match 0x12.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse once per second, after the time bytes have updated |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hour | input | 8 | Current hours, BCD with 12/24-hour bits |
| now_wday | input | 8 | Current weekday |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| int0_n | output | 1 | Active-low interrupt line 0 |
| int1_n | output | 1 | Active-low interrupt line 1 |

## Verification
The collision to provoke is a second-tick match together with a flag clear in the same cycle. The clear can come from a read of that alarm's registers or from a zero written to its status bit. The bench does this by raising `sec_tick` together with the read or write strobe while every alarm byte is set to match anything. It judges the outcome by reading the status register on the next cycle: both flags must still be set. A follow-up read without a tick must then clear only the addressed alarm's flag.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;
  localparam int BYTE_W     = 8;
  localparam int FIELD_CNT  = 4;
  localparam int ALARM_CNT  = 2;
  localparam int ALARM_BASE = 'h07;
  localparam int CTRL_ADDR  = 'h0F;
  localparam int STAT_ADDR  = 'h10;
  localparam int CTRL_W     = 3;

  typedef struct packed {
    logic sep;   // bit 2: alarm 1 on its own line
    logic en1;   // bit 1
    logic en0;   // bit 0
  } ctrl_t;
endpackage

// File: rtl/alarm_slot.sv
module alarm_slot #(
  parameter int DW   = 8,
  parameter int NF   = 4,
  parameter int AW   = 8,
  parameter int BASE = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic             tick,
  input  logic [NF*DW-1:0] now_vec,
  output logic             sel,
  output logic             rd_hit,
  output logic             match_hit,
  output logic [DW-1:0]    rdata
);
  logic [DW-1:0] fld_q [NF];
  logic [NF-1:0] fsel;
  logic [NF-1:0] feq;
  logic [NF-1:0] fld_we;

  for (genvar f = 0; f < NF; f++) begin : g_field
    assign fsel[f]   = (addr == AW'(BASE + f));
    assign fld_we[f] = wr_en & fsel[f];
    assign feq[f]    = fld_q[f][DW-1] |
                       ({1'b0, fld_q[f][DW-2:0]} == now_vec[f*DW +: DW]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          fld_q[f] <= '0;
      else if (fld_we[f])  fld_q[f] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int f = 0; f < NF; f++) begin
      if (fsel[f]) rdata = rdata | fld_q[f];
    end
  end

  assign sel       = |fsel;
  assign rd_hit    = rd_en & sel;
  assign match_hit = tick & (&feq);

  assert_notick_nomatch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |-> !match_hit);
endmodule

// File: rtl/alarm_flag_ctl.sv
module alarm_flag_ctl #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_req,
  input  logic [N-1:0] rd_clr,
  input  logic         st_wr,
  input  logic [N-1:0] st_keep,
  output logic [N-1:0] flag_q
);
  logic [N-1:0] clr;
  logic [N-1:0] flag_d;
  logic [N-1:0] flag_we;

  always_comb begin
    clr     = rd_clr | ({N{st_wr}} & ~st_keep);
    flag_d  = set_req | (flag_q & ~clr);
    flag_we = set_req | clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (flag_we[i]) flag_q[i] <= flag_d[i];
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    assert_no_spurious_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !set_req[i] |=> !$rose(flag_q[i]));
    assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[i] && !rd_clr[i] && !(st_wr && !st_keep[i])) |=> flag_q[i]);
    assert_rd_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr[i] && !set_req[i]) |=> !flag_q[i]);
    assert_st_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_wr && !st_keep[i] && !set_req[i]) |=> !flag_q[i]);
    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      set_req[i] |=> flag_q[i]);
  end
endmodule

// File: rtl/alarm_irq_route.sv
module alarm_irq_route
  import alarm_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] flag,
  input  ctrl_t      ctrl,
  output logic       int0_n,
  output logic       int1_n
);
  logic req0;
  logic req1;

  always_comb begin
    req0   = flag[0] & ctrl.en0;
    req1   = flag[1] & ctrl.en1;
    int0_n = ~(req0 | (req1 & ~ctrl.sep));
    int1_n = ~(req1 & ctrl.sep);
  end

  assert_int1_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.sep |-> int1_n);
  assert_one_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag[1] && ctrl.en1 && !(flag[0] && ctrl.en0)) |-> (int0_n != int1_n));
endmodule

// File: rtl/alarm_match_irq.sv
module alarm_match_irq
  import alarm_irq_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sec_tick,
  input  logic [DW-1:0] now_sec,
  input  logic [DW-1:0] now_min,
  input  logic [DW-1:0] now_hour,
  input  logic [DW-1:0] now_wday,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          int0_n,
  output logic          int1_n
);
  localparam int NA = ALARM_CNT;

  logic [FIELD_CNT*DW-1:0] now_vec;
  logic [NA-1:0]           slot_sel;
  logic [NA-1:0]           slot_rdhit;
  logic [NA-1:0]           slot_hit;
  logic [DW-1:0]           slot_rdata [NA];
  logic [NA-1:0]           flags;
  logic                    ctrl_sel;
  logic                    stat_sel;
  logic                    ctrl_we;
  ctrl_t                   ctrl_q;
  ctrl_t                   ctrl_d;
  logic [DW-1:0]           rd_mux;
  logic [DW-1:0]           rdata_q;

  assign now_vec = {now_wday, now_hour, now_min, now_sec};

  for (genvar a = 0; a < NA; a++) begin : g_slot
    alarm_slot #(
      .DW(DW), .NF(FIELD_CNT), .AW(AW), .BASE(ALARM_BASE + a*FIELD_CNT)
    ) u_slot (
      .clk(clk), .rst_n(rst_n),
      .wr_en(reg_wr), .rd_en(reg_rd), .addr(reg_addr), .wdata(reg_wdata),
      .tick(sec_tick), .now_vec(now_vec),
      .sel(slot_sel[a]), .rd_hit(slot_rdhit[a]),
      .match_hit(slot_hit[a]), .rdata(slot_rdata[a])
    );
  end

  assign ctrl_sel = (reg_addr == AW'(CTRL_ADDR));
  assign stat_sel = (reg_addr == AW'(STAT_ADDR));
  assign ctrl_we  = reg_wr & ctrl_sel;
  assign ctrl_d   = ctrl_t'(reg_wdata[CTRL_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_d;
  end

  alarm_flag_ctl #(.N(NA)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .set_req(slot_hit), .rd_clr(slot_rdhit),
    .st_wr(reg_wr & stat_sel), .st_keep(reg_wdata[NA-1:0]),
    .flag_q(flags)
  );

  alarm_irq_route u_route (
    .clk(clk), .rst_n(rst_n),
    .flag(flags), .ctrl(ctrl_q),
    .int0_n(int0_n), .int1_n(int1_n)
  );

  always_comb begin
    rd_mux = '0;
    for (int a = 0; a < NA; a++) begin
      if (slot_sel[a]) rd_mux = rd_mux | slot_rdata[a];
    end
    if (ctrl_sel) rd_mux = {{(DW-CTRL_W){1'b0}}, ctrl_q};
    if (stat_sel) rd_mux = {{(DW-NA){1'b0}}, flags};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (reg_rd) rdata_q <= rd_mux;
  end

  assign reg_rdata = rdata_q;

  assert_rd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));
  assert_ctrl_upper_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && ctrl_sel) |=> (reg_rdata[DW-1:CTRL_W] == '0));
endmodule

// File: tb/alarm_match_irq_tb.sv
module alarm_match_irq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 1'b0;
  logic [7:0] now_sec = '0, now_min = '0, now_hour = '0, now_wday = '0;
  logic [7:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       int0_n, int1_n;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  alarm_match_irq u_dut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
    .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour), .now_wday(now_wday),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .int0_n(int0_n), .int1_n(int1_n)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic step(input logic tk, input logic rd, input logic wr,
                      input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sec_tick = tk; reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    sec_tick = 1'b0; reg_rd = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    step(1'b0, 1'b0, 1'b1, a, d);
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    step(1'b0, 1'b1, 1'b0, a, 8'h00);
    d = reg_rdata;
  endtask

  task automatic tick();
    step(1'b1, 1'b0, 1'b0, 8'h00, 8'h00);
  endtask

  task automatic set_time(input logic [7:0] s, input logic [7:0] m,
                          input logic [7:0] h, input logic [7:0] w);
    now_sec = s; now_min = m; now_hour = h; now_wday = w;
  endtask

  task automatic fill(input int alarm, input logic [7:0] v);
    for (int f = 0; f < 4; f++) wr(8'(7 + 4*alarm + f), v);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    logic [7:0] sv [4];
    sv[0] = 8'h25; sv[1] = 8'h41; sv[2] = 8'h13; sv[3] = 8'h03;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 int0_n", {7'd0, int0_n}, 8'h01);
    chk("R1 int1_n", {7'd0, int1_n}, 8'h01);
    chk("R1 rdata", reg_rdata, 8'h00);
    rd(8'h10, d); chk("R1 status", d, 8'h00);
    rd(8'h0F, d); chk("R1 ctrl", d, 8'h00);
    rd(8'h09, d); chk("R1 alarm byte", d, 8'h00);

    // R2 readback of all eight alarm bytes
    for (int i = 0; i < 8; i++) wr(8'(7 + i), 8'(8'h31 + 8'(i*5)));
    for (int i = 0; i < 8; i++) begin
      rd(8'(7 + i), d); chk("R2 alarm readback", d, 8'(8'h31 + 8'(i*5)));
    end
    rd(8'h05, d); chk("R2 unmapped", d, 8'h00);
    fill(0, 8'h00); fill(1, 8'h00);

    // R3 sweep: per alarm, every disable mask against every mismatch pattern
    for (int a = 0; a < 2; a++) begin
      for (int mask = 0; mask < 16; mask++) begin
        for (int f = 0; f < 4; f++)
          wr(8'(7 + 4*a + f), sv[f] | (mask[f] ? 8'h80 : 8'h00));
        for (int diff = 0; diff < 16; diff++) begin
          wr(8'h10, 8'h00);
          set_time(sv[0] ^ (diff[0] ? 8'h01 : 8'h00), sv[1] ^ (diff[1] ? 8'h01 : 8'h00),
                   sv[2] ^ (diff[2] ? 8'h01 : 8'h00), sv[3] ^ (diff[3] ? 8'h01 : 8'h00));
          tick();
          rd(8'h10, d);
          chk("R3 match sweep", d, ((diff & ~mask & 15) == 0) ? 8'(1 << a) : 8'h00);
        end
      end
      fill(a, 8'h00);
    end
    // R3 no tick means no set
    fill(0, 8'h80); wr(8'h10, 8'h00);
    step(1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
    rd(8'h10, d); chk("R3 no tick", d, 8'h00);

    // R4 sticky flag
    for (int f = 0; f < 4; f++) wr(8'(7 + f), sv[f]);
    set_time(sv[0], sv[1], sv[2], sv[3]); tick();
    set_time(8'h26, sv[1], sv[2], sv[3]); tick();
    rd(8'h10, d); chk("R4 sticky", d, 8'h01);
    tick();
    rd(8'h10, d); chk("R4 sticky again", d, 8'h01);

    // R5 / R6 / R7 with both alarms matching anything
    fill(0, 8'h80); fill(1, 8'h80);
    wr(8'h10, 8'h00);
    step(1'b1, 1'b1, 1'b0, 8'h07, 8'h00);
    rd(8'h10, d); chk("R7 tick with alarm read", d, 8'h03);
    step(1'b1, 1'b0, 1'b1, 8'h10, 8'h00);
    rd(8'h10, d); chk("R7 tick with status clear", d, 8'h03);
    rd(8'h0A, d); rd(8'h10, d); chk("R5 read alarm0 clears flag0 only", d, 8'h02);
    rd(8'h0C, d); rd(8'h10, d); chk("R5 read alarm1 clears flag1", d, 8'h00);
    tick(); wr(8'h10, 8'h02);
    rd(8'h10, d); chk("R6 keep flag1", d, 8'h02);
    wr(8'h10, 8'h01);
    rd(8'h10, d); chk("R6 clear flag1", d, 8'h00);

    // R8 / R9 routing over every control and flag combination
    for (int c = 0; c < 8; c++) begin
      for (int f = 0; f < 4; f++) begin
        logic a0, a1;
        wr(8'h0F, 8'(c));
        wr(8'h10, 8'h00); tick(); wr(8'h10, 8'(f));
        a0 = f[0] & c[0];
        a1 = f[1] & c[1];
        chk("R8 int0_n", {7'd0, int0_n}, {7'd0, ~(a0 | (a1 & ~c[2]))});
        chk("R9 int1_n", {7'd0, int1_n}, {7'd0, ~(a1 & c[2])});
      end
    end

    // R10 control width and status read without clearing
    wr(8'h0F, 8'hFF);
    rd(8'h0F, d); chk("R10 ctrl upper bits", d, 8'h07);
    wr(8'h10, 8'h00); tick();
    rd(8'h10, d); rd(8'h10, d); chk("R10 status read keeps flags", d, 8'h03);

    // R11 hour compared as raw bits
    fill(1, 8'h00); fill(0, 8'h80); wr(8'h09, 8'h52);
    wr(8'h10, 8'h00);
    set_time(8'h00, 8'h00, 8'h12, 8'h01); tick();
    rd(8'h10, d); chk("R11 24h hour vs 12h alarm", d, 8'h00);
    set_time(8'h00, 8'h00, 8'h52, 8'h01); tick();
    rd(8'h10, d); chk("R11 12h hour match", d, 8'h01);

    finish_run();
  end
endmodule